// File: doc/BRIEF.md
# Width-Matching Dual-Clock FIFO with Selectable Lane Order

This block is a first-in, first-out buffer that joins two clock domains whose data buses may differ in width. Each side works either as a narrow 9-bit port or as a wide 18-bit port. The choice for each side is independent of the other. A wide word is made of two 9-bit lanes. When the widths differ, the block splits each wide word into two narrow words, or it joins two narrow words into one wide word. A lane-order setting chooses which half of a wide word comes first in the stream: the upper half (big-endian) or the lower half (little-endian).

The two widths and the lane order are sampled while the master reset is held low. After reset is released they stay fixed, whatever the configuration pins do. Storage is an inferred RAM split into two 9-bit banks. Its capacity is fixed at `2*WORDS` lanes, so a wide port holds half as many words as a narrow one.

Occupancy is tracked in lanes. Each side keeps a count of its own transfers and sends it across as Gray code through two flops. The receiving side scales that count by the other port's width. Empty and full therefore never lose or repeat half of a word, and a half-filled wide word is never offered to the reader.

Top module: `width_match_fifo`

## Requirements
- R1: While master reset is low and in the first cycle after it is released, `empty` is 1, `full` is 0 and `rdData` is all zeros.
- R2: `cfgWrWide`, `cfgRdWide` and `cfgBigEnd` are sampled only while `mrstN` is low. Changing them after release has no effect on the data order or the widths.
- R3: With equal port widths, words come out in the order they were written and with the same value. On a narrow port only bits [8:0] carry data: written bits [17:9] are ignored and read bits [17:9] are zero.
- R4: With an 18-bit write port and a 9-bit read port, each written word produces two reads. If `cfgBigEnd`=1, bits [17:9] come out first. If `cfgBigEnd`=0, bits [8:0] come out first.
- R5: With a 9-bit write port and an 18-bit read port, two consecutive writes form one read word. If `cfgBigEnd`=1, the first write goes in bits [17:9]. If `cfgBigEnd`=0, the first write goes in bits [8:0].
- R6: With a 9-bit write port and an 18-bit read port, a single unpaired narrow write leaves `empty` at 1.
- R7: Capacity is `2*WORDS` lanes. `full` rises once fewer free lanes remain than one write needs (1 lane narrow, 2 lanes wide). A write attempted while `full` is 1 is dropped.
- R8: A read attempted while `empty` is 1 is ignored. `rdData` holds its value and the read position does not move.
- R9: `rdData` changes only on a read-clock edge where `rdEn` is 1 and `empty` is 0.
- R10: `full` can rise only after an accepted write. `empty` can rise only after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, active low, synchronous in each domain; configuration is sampled while low |
| cfgWrWide | input | 1 | Write port width: 1 = 18 bits, 0 = 9 bits |
| cfgRdWide | input | 1 | Read port width: 1 = 18 bits, 0 = 9 bits |
| cfgBigEnd | input | 1 | Lane order: 1 = upper lane first, 0 = lower lane first |
| wrEn | input | 1 | Write request, taken on the rising `wrClk` edge when not full |
| wrData | input | 18 | Write data; only [8:0] is used on a narrow write port |
| full | output | 1 | Not enough free lanes for one more write |
| rdEn | input | 1 | Read request, taken on the rising `rdClk` edge when not empty |
| rdData | output | 18 | Registered read data; [17:9] is zero on a narrow read port |
| empty | output | 1 | Not enough stored lanes for one read |

## Verification
The checks assume the following about the inputs:
- The configuration pins are steady for at least two edges of each clock before `mrstN` is released.
- `mrstN` is held low for several edges of both clocks.
- Pointer movement comes only from the enables, so a rising flag can be traced back to an accepted transfer on its own side.

The stimulus meets these assumptions:
- It sets the pins before asserting reset, holds reset for four cycles of each clock and releases it at a falling write-clock edge.
- It changes the pins only after release, to show that they are ignored.
- It drives enables and data only at falling clock edges.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

  // Configuration sampled during master reset
  typedef struct packed {
    logic wrWide;   // write port carries two lanes
    logic rdWide;   // read port carries two lanes
    logic bigEnd;   // upper lane travels first
  } fifoCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic we0;      // write lane bank 0
    logic we1;      // write lane bank 1
    logic rdGo;     // accepted read
    logic rdLane;   // bank selected for a narrow read
  } laneStrb_t;

  localparam int LANE_W = 9;

endpackage

// File: rtl/wmf_ctrl.sv
module wmf_ctrl
  import wmf_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            mrstN,
  input  fifoCfg_t        cfgIn,
  input  logic            wrEn,
  input  logic            rdEn,
  output fifoCfg_t        cfgW,
  output fifoCfg_t        cfgR,
  output laneStrb_t       strb,
  output logic [$clog2(WORDS)-1:0] wrRow,
  output logic [$clog2(WORDS)-1:0] rdRow,
  output logic            full,
  output logic            empty
);

  localparam int RW = $clog2(WORDS);
  localparam int LW = RW + 2;                 // lane pointer with wrap bit
  localparam logic [LW-1:0] CAPV = LW'(2 * WORDS);
  localparam logic [LW-1:0] ONE  = LW'(1);
  localparam logic [LW-1:0] TWO  = LW'(2);

  function automatic logic [LW-1:0] toGray(input logic [LW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [LW-1:0] fromGray(input logic [LW-1:0] g);
    logic [LW-1:0] b;
    b[LW-1] = g[LW-1];
    for (int i = LW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  fifoCfg_t        cfgWq;
  logic [LW-1:0]   wrCnt, wrGray, rdGs1, rdGs2;
  logic [LW-1:0]   wrPos, rdPosAtW, usedW, wrStep, rdCntAtW;
  logic            wrGo;

  // ---------------- read domain -----------------
  fifoCfg_t        cfgRq;
  logic [LW-1:0]   rdCnt, rdGray, wrGs1, wrGs2;
  logic [LW-1:0]   rdPos, wrPosAtR, usedR, rdStep, wrCntAtR;
  logic            rdGo;

  always_comb begin
    rdCntAtW = fromGray(rdGs2);
    wrPos    = cfgWq.wrWide ? {wrCnt[LW-2:0], 1'b0} : wrCnt;
    rdPosAtW = cfgWq.rdWide ? {rdCntAtW[LW-2:0], 1'b0} : rdCntAtW;
    usedW    = wrPos - rdPosAtW;
    wrStep   = cfgWq.wrWide ? TWO : ONE;
    full     = usedW > (CAPV - wrStep);
    wrGo     = wrEn & ~full;
  end

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      cfgWq  <= cfgIn;
      wrCnt  <= '0;
      wrGray <= '0;
      rdGs1  <= '0;
      rdGs2  <= '0;
    end else begin
      rdGs1 <= rdGray;
      rdGs2 <= rdGs1;
      if (wrGo) begin
        wrCnt  <= wrCnt + ONE;
        wrGray <= toGray(wrCnt + ONE);
      end
    end
  end

  always_comb begin
    wrCntAtR = fromGray(wrGs2);
    rdPos    = cfgRq.rdWide ? {rdCnt[LW-2:0], 1'b0} : rdCnt;
    wrPosAtR = cfgRq.wrWide ? {wrCntAtR[LW-2:0], 1'b0} : wrCntAtR;
    usedR    = wrPosAtR - rdPos;
    rdStep   = cfgRq.rdWide ? TWO : ONE;
    empty    = usedR < rdStep;
    rdGo     = rdEn & ~empty;
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      cfgRq  <= cfgIn;
      rdCnt  <= '0;
      rdGray <= '0;
      wrGs1  <= '0;
      wrGs2  <= '0;
    end else begin
      wrGs1 <= wrGray;
      wrGs2 <= wrGs1;
      if (rdGo) begin
        rdCnt  <= rdCnt + ONE;
        rdGray <= toGray(rdCnt + ONE);
      end
    end
  end

  assign cfgW        = cfgWq;
  assign cfgR        = cfgRq;
  assign wrRow       = wrPos[LW-2:1];
  assign rdRow       = rdPos[LW-2:1];
  assign strb.we0    = wrGo & (cfgWq.wrWide | ~wrPos[0]);
  assign strb.we1    = wrGo & (cfgWq.wrWide |  wrPos[0]);
  assign strb.rdGo   = rdGo;
  assign strb.rdLane = rdPos[0];

endmodule

// File: rtl/wmf_datapath.sv
module wmf_datapath
  import wmf_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            mrstN,
  input  fifoCfg_t        cfgW,
  input  fifoCfg_t        cfgR,
  input  laneStrb_t       strb,
  input  logic [$clog2(WORDS)-1:0] wrRow,
  input  logic [$clog2(WORDS)-1:0] rdRow,
  input  logic [2*LANE_W-1:0]      wrData,
  output logic [2*LANE_W-1:0]      rdData
);

  localparam int NBANK = 2;

  logic [LANE_W-1:0] hiIn, loIn, firstIn, secondIn;
  logic [NBANK-1:0][LANE_W-1:0] bankData;
  logic [NBANK-1:0]             bankWe;
  logic [LANE_W-1:0]            q0, q1;
  logic                         phaseQ;

  always_comb begin
    hiIn        = wrData[2*LANE_W-1:LANE_W];
    loIn        = wrData[LANE_W-1:0];
    firstIn     = cfgW.bigEnd ? hiIn : loIn;
    secondIn    = cfgW.bigEnd ? loIn : hiIn;
    bankData[0] = cfgW.wrWide ? firstIn  : loIn;
    bankData[1] = cfgW.wrWide ? secondIn : loIn;
    bankWe[0]   = strb.we0;
    bankWe[1]   = strb.we1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : bankG
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] q;

    always_ff @(posedge wrClk) begin
      if (bankWe[b]) mem[wrRow] <= bankData[b];
    end

    always_ff @(posedge rdClk) begin
      if (!mrstN)         q <= '0;
      else if (strb.rdGo) q <= mem[rdRow];
    end
  end

  assign q0 = bankG[0].q;
  assign q1 = bankG[1].q;

  always_ff @(posedge rdClk) begin
    if (!mrstN)         phaseQ <= 1'b0;
    else if (strb.rdGo) phaseQ <= strb.rdLane;
  end

  always_comb begin
    if (cfgR.rdWide) rdData = cfgR.bigEnd ? {q0, q1} : {q1, q0};
    else             rdData = {{LANE_W{1'b0}}, (phaseQ ? q1 : q0)};
  end

endmodule

// File: rtl/width_match_fifo.sv
module width_match_fifo
  import wmf_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        mrstN,
  input  logic        cfgWrWide,
  input  logic        cfgRdWide,
  input  logic        cfgBigEnd,
  input  logic        wrEn,
  input  logic [17:0] wrData,
  output logic        full,
  input  logic        rdEn,
  output logic [17:0] rdData,
  output logic        empty
);

  localparam int RW = $clog2(WORDS);

  fifoCfg_t        cfgIn, cfgW, cfgR;
  laneStrb_t       strb;
  logic [RW-1:0]   wrRow, rdRow;

  assign cfgIn = '{wrWide: cfgWrWide, rdWide: cfgRdWide, bigEnd: cfgBigEnd};

  wmf_ctrl #(.WORDS(WORDS)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .cfgIn(cfgIn),
    .wrEn(wrEn), .rdEn(rdEn), .cfgW(cfgW), .cfgR(cfgR), .strb(strb),
    .wrRow(wrRow), .rdRow(rdRow), .full(full), .empty(empty)
  );

  wmf_datapath #(.WORDS(WORDS)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .cfgW(cfgW), .cfgR(cfgR),
    .strb(strb), .wrRow(wrRow), .rdRow(rdRow), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/wmf_checker.sv
module wmf_checker
  import wmf_pkg::*;
(
  input logic        wrClk,
  input logic        rdClk,
  input logic        mrstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic        full,
  input logic        empty,
  input logic [17:0] rdData,
  input fifoCfg_t    cfgW,
  input fifoCfg_t    cfgR,
  input logic        we0,
  input logic        we1
);

  // R10
  full_rise_chk: assert property (@(posedge wrClk) disable iff (!mrstN)
    $rose(full) |-> $past(wrEn));

  // R10
  empty_rise_chk: assert property (@(posedge rdClk) disable iff (!mrstN)
    $rose(empty) |-> $past(rdEn));

  // R9
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (!mrstN)
    !(rdEn && !empty) |=> $stable(rdData));

  // R8
  empty_hold_chk: assert property (@(posedge rdClk) disable iff (!mrstN)
    empty |=> $stable(rdData));

  // R2
  cfg_w_chk: assert property (@(posedge wrClk) disable iff (!mrstN)
    $stable(cfgW));

  // R2
  cfg_r_chk: assert property (@(posedge rdClk) disable iff (!mrstN)
    $stable(cfgR));

  // R7
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!mrstN)
    full |-> !(we0 || we1));

  // R3
  narrow_lane_chk: assert property (@(posedge wrClk) disable iff (!mrstN)
    !cfgW.wrWide |-> $onehot0({we0, we1}));

endmodule

bind width_match_fifo wmf_checker u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .wrEn(wrEn), .rdEn(rdEn),
  .full(full), .empty(empty), .rdData(rdData), .cfgW(cfgW), .cfgR(cfgR),
  .we0(strb.we0), .we1(strb.we1)
);

// File: tb/sim_width_match_fifo.sv
`timescale 1ns/1ps
module sim_width_match_fifo;

  localparam int WORDS = 16;
  localparam int CAP   = 2 * WORDS;

  logic wrClk = 1'b0, rdClk = 1'b0;
  always #2.5 wrClk = ~wrClk;   // 200 MHz
  always #3.5 rdClk = ~rdClk;

  logic        mrstN = 1'b0;
  logic        cfgWrWide = 1'b0, cfgRdWide = 1'b0, cfgBigEnd = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic        full, empty;

  width_match_fifo #(.WORDS(WORDS)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .cfgWrWide(cfgWrWide), .cfgRdWide(cfgRdWide), .cfgBigEnd(cfgBigEnd),
    .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdEn(rdEn), .rdData(rdData), .empty(empty)
  );

  int          vectors = 0, errors = 0;
  logic [8:0]  sb[$];
  bit          rdAllow = 0, rdPoke = 0, pend = 0, finished = 0;
  bit          cW, cR, cB;
  string       tag = "R1";
  logic [17:0] hold;

  task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard compare of one completed read
  task automatic compareOut();
    logic [8:0]  a, b;
    logic [17:0] e;
    int need;
    need = cR ? 2 : 1;
    if (sb.size() < need) begin
      check(1'b0, {tag, " (unexpected read)"}, rdData, 18'h0);
    end else begin
      a = sb.pop_front();
      if (cR) begin
        b = sb.pop_front();
        e = cB ? {a, b} : {b, a};
      end else begin
        e = {9'd0, a};
      end
      check(rdData === e, tag, rdData, e);
    end
  endtask

  // Monitor: issues reads and compares results
  initial begin
    forever begin
      @(negedge rdClk);
      if (!mrstN) begin
        pend  = 0;
        rdEn  = 1'b0;
      end else begin
        if (pend) begin
          pend = 0;
          compareOut();
        end
        if (rdAllow && !empty && ($urandom_range(0, 3) != 0)) begin
          rdEn = 1'b1;
          pend = 1;
        end else if (rdPoke) begin
          rdEn = 1'b1;
        end else begin
          rdEn = 1'b0;
        end
      end
    end
  end

  // Driver: one write, pushes expected lanes in stream order
  task automatic putWord(input logic [17:0] d);
    @(negedge wrClk);
    while (full) @(negedge wrClk);
    wrEn   = 1'b1;
    wrData = d;
    if (cW) begin
      sb.push_back(cB ? d[17:9] : d[8:0]);
      sb.push_back(cB ? d[8:0]  : d[17:9]);
    end else begin
      sb.push_back(d[8:0]);
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic drain();
    rdAllow = 1;
    while (sb.size() != 0) @(negedge rdClk);
    repeat (12) @(negedge rdClk);
    rdAllow = 0;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic doReset(input bit w, input bit r, input bit b);
    mrstN   = 1'b0;
    wrEn    = 1'b0;
    rdAllow = 0;
    rdPoke  = 0;
    cfgWrWide = w; cfgRdWide = r; cfgBigEnd = b;
    cW = w; cR = r; cB = b;
    sb.delete();
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
    mrstN = 1'b1;
    @(negedge wrClk);
    @(negedge rdClk);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      doReset(c[2], c[1], c[0]);
      // R1 reset state
      check(empty === 1'b1, "R1", {17'd0, empty}, 18'd1);
      check(full === 1'b0, "R1", {17'd0, full}, 18'd0);
      check(rdData === 18'd0, "R1", rdData, 18'd0);

      // R2: pins flipped after release must not matter
      cfgWrWide = ~cW; cfgRdWide = ~cR; cfgBigEnd = ~cB;
      tag = (cW == cR) ? "R3 R2" : (cW ? "R4 R2" : "R5 R2");
      rdAllow = 1;
      for (int i = 0; i < 24; i++) putWord(18'($urandom));
      drain();
      check(empty === 1'b1, tag, {17'd0, empty}, 18'd1);

      // R7 fill to capacity with reads stopped
      tag = "R7";
      for (int i = 0; i < CAP / (cW ? 2 : 1) - 1; i++) putWord(18'($urandom));
      check(full === 1'b0, "R7 one write short", {17'd0, full}, 18'd0);
      putWord(18'($urandom));
      check(full === 1'b1, "R7 at capacity", {17'd0, full}, 18'd1);
      @(negedge wrClk);
      wrEn = 1'b1; wrData = 18'h3_ABCD;
      @(negedge wrClk);
      wrEn = 1'b0;
      check(full === 1'b1, "R7 write while full", {17'd0, full}, 18'd1);
      repeat (20) @(negedge wrClk);
      check(full === 1'b1, "R10 full holds", {17'd0, full}, 18'd1);
      drain();
      check(empty === 1'b1, "R7 drained", {17'd0, empty}, 18'd1);
      repeat (20) @(negedge rdClk);
      check(empty === 1'b1, "R10 empty holds", {17'd0, empty}, 18'd1);

      // R8 reads on empty are ignored
      tag  = "R8";
      hold = rdData;
      rdPoke = 1;
      repeat (6) @(negedge rdClk);
      rdPoke = 0;
      @(negedge rdClk);
      check(rdData === hold, "R8 R9 data held", rdData, hold);
      check(empty === 1'b1, "R8", {17'd0, empty}, 18'd1);
      putWord(18'h1_2345);
      putWord(18'h2_6789);
      drain();

      // R6 half-packed word stays invisible
      if (!cW && cR) begin
        tag = "R6";
        putWord(18'h0_0155);
        repeat (10) @(negedge rdClk);
        check(empty === 1'b1, "R6 single lane", {17'd0, empty}, 18'd1);
        putWord(18'h0_00AA);
        drain();
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  // Watchdog
  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule